// File: doc/BRIEF.md
# Event Timer Register File and Main Counter

This block is the shared front end of a multi-channel event timer. It sits on a simple 32-bit word-addressed read/write bus and covers a 1 KB window. It owns a read-only capability word pair, a global configuration register holding an enable bit and a legacy-route bit, a view of the channels' interrupt status bits, and a free-running 64-bit main counter. The counter advances by one on every tick cycle while the block is enabled. While the block is disabled the counter freezes, and software can load it in two 32-bit halves.

The upper three quarters of the window hold one 32-byte slot per channel. The block decodes these slots and passes the write strobe, the word offset and the write data to the selected channel in the same cycle. It returns that channel's read data on the bus. Slots above the implemented channel count read as zero, and writes to them reach no channel.

When the enable bit turns on, the block sends a one-cycle arm pulse to every channel whose comparator is not all ones. When the enable bit turns off, it sends a one-cycle disarm pulse to every channel. The channels themselves and the routing of their interrupts are built elsewhere.

Top module: `evt_regfile`

## Requirements
- R1: A read request returns its data on `rsp_rdata` with `rsp_valid` high exactly one clock cycle after the request cycle. A write produces no `rsp_valid`.
- R2: Word 0x00 (byte 0x000) reads 0x8086A001 with NUM_CH-1 placed in bits 12:8. Word 0x01 (byte 0x004) reads the tick period in femtoseconds. Writes to both words are ignored.
- R3: While the enable bit is set, the main counter increases by exactly one in every cycle where `tick` is high, with carry from the low half into the high half.
- R4: While the enable bit is clear, the counter keeps its value whatever `tick` does. Writes to word 0x3C (byte 0x0F0) load bits 31:0 and writes to word 0x3D (byte 0x0F4) load bits 63:32, and both halves read back.
- R5: Word 0x04 (byte 0x010) is the configuration: bit 0 is enable and bit 1 is legacy route. Only these two bits are written, and all other bits read zero. Word 0x05 (byte 0x014) reads zero and ignores writes.
- R6: A write that sets enable from 0 to 1 raises `arm_o` for one cycle, with bit i set exactly where `chan_cmp_max[i]` was low in the write cycle. A write that clears enable from 1 to 0 raises every bit of `disarm_o` for one cycle. The two pulses never overlap.
- R7: Word addresses 0x40 to 0xFF map to channel slot (waddr-0x40)/8 with word offset waddr[2:0]. A write to slot i<NUM_CH raises only `chan_wr[i]` in the same cycle, with `chan_off` and `chan_wdata` valid. A read returns word `chan_rdata[i]`.
- R8: A slot index of NUM_CH or above reads zero and raises no channel strobe.
- R9: Word 0x08 (byte 0x020) reads `chan_status` zero-extended, and word 0x09 reads zero. A write to word 0x08 raises `sts_clr` in the same cycle, equal to the written bits ANDed with `chan_status`.
- R10: After reset the counter is zero, the configuration is zero, and no pulse, strobe or response is active.
- R11: Global word addresses that decode to no register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advance qualifier |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_waddr | input | 8 | Word address (byte address bits 9:2) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| chan_wr | output | NUM_CH | One-hot channel write strobe |
| chan_rd | output | NUM_CH | One-hot channel read strobe |
| chan_off | output | 3 | Word offset inside the channel slot |
| chan_wdata | output | 32 | Write data forwarded to channels |
| chan_rdata | input | 32*NUM_CH | Per-channel read data, channel i in bits 32i+31:32i |
| chan_cmp_max | input | NUM_CH | Channel comparator is all ones |
| chan_status | input | NUM_CH | Channel interrupt status bits |
| sts_clr | output | NUM_CH | Status clear strobe to channels |
| arm_o | output | NUM_CH | One-cycle re-arm pulse |
| disarm_o | output | NUM_CH | One-cycle disarm pulse |
| count_o | output | 64 | Main counter value |
| enabled_o | output | 1 | Configuration enable bit |
| legacy_o | output | 1 | Configuration legacy-route bit |

## Verification
Channel strobes, offset, forwarded data and `sts_clr` are combinational from the request, so the bench checks them shortly after it drives the request, before the capturing edge. Read data, the configuration outputs and the arm/disarm pulses appear one edge after the request cycle, and the bench samples them at the following falling edge. Counter results are due one edge after each tick cycle. The bench therefore counts the ticking falling edges and compares `count_o` once ticking has stopped.

// File: rtl/evt_regfile_pkg.sv
package evt_regfile_pkg;

    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int OFF_W  = 3;
    localparam int SLOT_W = 5;

    // Global word addresses
    localparam logic [AW-1:0] WA_CAP_LO = 8'h00;
    localparam logic [AW-1:0] WA_CAP_HI = 8'h01;
    localparam logic [AW-1:0] WA_CFG_LO = 8'h04;
    localparam logic [AW-1:0] WA_CFG_HI = 8'h05;
    localparam logic [AW-1:0] WA_STS_LO = 8'h08;
    localparam logic [AW-1:0] WA_STS_HI = 8'h09;
    localparam logic [AW-1:0] WA_CNT_LO = 8'h3C;
    localparam logic [AW-1:0] WA_CNT_HI = 8'h3D;
    localparam logic [AW-1:0] WA_CHAN0  = 8'h40;

    localparam logic [DW-1:0] CAP_BASE  = 32'h8086_A001;
    localparam int            CAP_NSHIFT = 8;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CAP_LO,
        RG_CAP_HI,
        RG_CFG_LO,
        RG_CFG_HI,
        RG_STS_LO,
        RG_STS_HI,
        RG_CNT_LO,
        RG_CNT_HI,
        RG_CHAN
    } region_e;

    typedef struct packed {
        region_e             region;
        logic [SLOT_W-1:0]   slot;
        logic [OFF_W-1:0]    woff;
        logic                slot_ok;
    } dec_t;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] rdata;
    } rsp_t;

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
    import evt_regfile_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [AW-1:0] waddr,
    output dec_t          dec
);
    localparam logic [SLOT_W-1:0] SLOT_LIMIT = SLOT_W'(NUM_CH);

    logic [AW-1:0] rel;

    always_comb begin
        rel         = waddr - WA_CHAN0;
        dec.region  = RG_NONE;
        dec.slot    = rel[AW-1:OFF_W];
        dec.woff    = waddr[OFF_W-1:0];
        dec.slot_ok = 1'b0;
        if (waddr >= WA_CHAN0) begin
            dec.region  = RG_CHAN;
            dec.slot_ok = (rel[AW-1:OFF_W] < SLOT_LIMIT);
        end else begin
            unique case (waddr)
                WA_CAP_LO: dec.region = RG_CAP_LO;
                WA_CAP_HI: dec.region = RG_CAP_HI;
                WA_CFG_LO: dec.region = RG_CFG_LO;
                WA_CFG_HI: dec.region = RG_CFG_HI;
                WA_STS_LO: dec.region = RG_STS_LO;
                WA_STS_HI: dec.region = RG_STS_HI;
                WA_CNT_LO: dec.region = RG_CNT_LO;
                WA_CNT_HI: dec.region = RG_CNT_HI;
                default:   dec.region = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_regfile_pkg::*;
#(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] count
);
    localparam int HI_W = CW - DW;

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (wr_lo) begin
            count_d[DW-1:0] = wdata;
        end else if (wr_hi) begin
            count_d[CW-1:DW] = wdata[HI_W-1:0];
        end else if (run && tick) begin
            count_d = count_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

endmodule

// File: rtl/evt_cfg_ctrl.sv
module evt_cfg_ctrl #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        wbits,
    input  logic [NUM_CH-1:0] cmp_max,
    output logic              enable,
    output logic              legacy,
    output logic [NUM_CH-1:0] arm,
    output logic [NUM_CH-1:0] disarm
);
    typedef struct packed {
        logic              en;
        logic              leg;
        logic [NUM_CH-1:0] arm;
        logic [NUM_CH-1:0] disarm;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d        = cfg_q;
        cfg_d.arm    = '0;
        cfg_d.disarm = '0;
        if (wr) begin
            cfg_d.en  = wbits[0];
            cfg_d.leg = wbits[1];
            if (!cfg_q.en && wbits[0]) cfg_d.arm    = ~cmp_max;
            if (cfg_q.en && !wbits[0]) cfg_d.disarm = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign enable = cfg_q.en;
    assign legacy = cfg_q.leg;
    assign arm    = cfg_q.arm;
    assign disarm = cfg_q.disarm;

endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
    import evt_regfile_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter logic [31:0] PERIOD_FS = 32'h05F5_E100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [7:0]           req_waddr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic [NUM_CH-1:0]    chan_wr,
    output logic [NUM_CH-1:0]    chan_rd,
    output logic [2:0]           chan_off,
    output logic [31:0]          chan_wdata,
    input  logic [32*NUM_CH-1:0] chan_rdata,
    input  logic [NUM_CH-1:0]    chan_cmp_max,
    input  logic [NUM_CH-1:0]    chan_status,
    output logic [NUM_CH-1:0]    sts_clr,
    output logic [NUM_CH-1:0]    arm_o,
    output logic [NUM_CH-1:0]    disarm_o,
    output logic [63:0]          count_o,
    output logic                 enabled_o,
    output logic                 legacy_o
);
    localparam int            CW      = 64;
    localparam logic [DW-1:0] CAP_LO  = CAP_BASE | (DW'(NUM_CH - 1) << CAP_NSHIFT);
    localparam logic [DW-1:0] CAP_HI  = PERIOD_FS;

    dec_t          dec;
    logic          wr_req, rd_req;
    logic [DW-1:0] chan_sel_data;
    rsp_t          rsp_d, rsp_q;

    evt_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .waddr (req_waddr),
        .dec   (dec)
    );

    assign wr_req = req_valid && req_write;
    assign rd_req = req_valid && !req_write;

    evt_main_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enabled_o),
        .tick  (tick),
        .wr_lo (wr_req && dec.region == RG_CNT_LO),
        .wr_hi (wr_req && dec.region == RG_CNT_HI),
        .wdata (req_wdata),
        .count (count_o)
    );

    evt_cfg_ctrl #(.NUM_CH(NUM_CH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_req && dec.region == RG_CFG_LO),
        .wbits   (req_wdata[1:0]),
        .cmp_max (chan_cmp_max),
        .enable  (enabled_o),
        .legacy  (legacy_o),
        .arm     (arm_o),
        .disarm  (disarm_o)
    );

    // Per-channel strobes, one generated lane per channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        logic hit;
        assign hit        = dec.region == RG_CHAN && dec.slot_ok &&
                            dec.slot == SLOT_W'(g);
        assign chan_wr[g] = wr_req && hit;
        assign chan_rd[g] = rd_req && hit;
    end

    assign chan_off   = dec.woff;
    assign chan_wdata = req_wdata;
    assign sts_clr    = (wr_req && dec.region == RG_STS_LO) ?
                        (req_wdata[NUM_CH-1:0] & chan_status) : '0;

    always_comb begin
        chan_sel_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (dec.slot == SLOT_W'(i)) chan_sel_data = chan_rdata[i*DW +: DW];
        end
    end

    always_comb begin
        rsp_d.valid = rd_req;
        rsp_d.rdata = '0;
        if (rd_req) begin
            unique case (dec.region)
                RG_CAP_LO: rsp_d.rdata = CAP_LO;
                RG_CAP_HI: rsp_d.rdata = CAP_HI;
                RG_CFG_LO: rsp_d.rdata = {30'd0, legacy_o, enabled_o};
                RG_STS_LO: rsp_d.rdata = DW'(chan_status);
                RG_CNT_LO: rsp_d.rdata = count_o[DW-1:0];
                RG_CNT_HI: rsp_d.rdata = count_o[CW-1:DW];
                RG_CHAN:   rsp_d.rdata = dec.slot_ok ? chan_sel_data : '0;
                default:   rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.rdata;

endmodule

// File: rtl/evt_regfile_chk.sv
module evt_regfile_chk #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              req_valid,
    input logic              req_write,
    input logic [7:0]        req_waddr,
    input logic              rsp_valid,
    input logic [NUM_CH-1:0] chan_wr,
    input logic [NUM_CH-1:0] chan_rd,
    input logic [NUM_CH-1:0] chan_cmp_max,
    input logic [NUM_CH-1:0] arm_o,
    input logic [NUM_CH-1:0] disarm_o,
    input logic [63:0]       count_o,
    input logic              enabled_o
);
    logic cnt_wr;
    assign cnt_wr = req_valid && req_write &&
                    (req_waddr == 8'h3C || req_waddr == 8'h3D);

    p_rsp_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    p_no_rsp_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_write) |=> !rsp_valid);

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled_o && tick && !cnt_wr) |=> count_o == $past(count_o) + 64'd1);

    p_cnt_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled_o && !cnt_wr) |=> $stable(count_o));

    p_arm_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enabled_o) |-> arm_o == ~$past(chan_cmp_max));

    p_disarm_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enabled_o) |-> disarm_o == '1);

    p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !((|arm_o) && (|disarm_o)));

    p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_wr) && $onehot0(chan_rd));

endmodule

bind evt_regfile evt_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_waddr    (req_waddr),
    .rsp_valid    (rsp_valid),
    .chan_wr      (chan_wr),
    .chan_rd      (chan_rd),
    .chan_cmp_max (chan_cmp_max),
    .arm_o        (arm_o),
    .disarm_o     (disarm_o),
    .count_o      (count_o),
    .enabled_o    (enabled_o)
);

// File: tb/tb_evt_regfile.sv
module tb_evt_regfile;
    localparam int          CLK_PERIOD = 10;
    localparam int          NCH        = 3;
    localparam logic [31:0] PER        = 32'h05F5_E100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [7:0]        req_waddr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [NCH-1:0]    chan_wr, chan_rd, sts_clr, arm_o, disarm_o;
    logic [2:0]        chan_off;
    logic [31:0]       chan_wdata;
    logic [32*NCH-1:0] chan_rdata;
    logic [NCH-1:0]    chan_cmp_max = 3'b010;
    logic [NCH-1:0]    chan_status  = 3'b101;
    logic [63:0]       count_o;
    logic              enabled_o, legacy_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Channel i answers 0xC0DE_0000 | i<<8 | word offset
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign chan_rdata[g*32 +: 32] = 32'hC0DE_0000 | (32'(g) << 8) | 32'(chan_off);
    end

    evt_regfile #(.NUM_CH(NCH), .PERIOD_FS(PER)) dut (.*);

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus(bit wr, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_waddr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        bus(1'b0, a, 32'h0);
        check({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check(tag, 64'(rsp_rdata), 64'(exp));
    endtask

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 32'h0, 32'h8086_A201},  // R2 capability low, count field 2
        '{1'b0, 8'h01, 32'h0, 32'h05F5_E100},  // R2 period word
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},  // R2 write ignored
        '{1'b0, 8'h00, 32'h0, 32'h8086_A201},  // R2
        '{1'b1, 8'h04, 32'hFFFF_FFF2, 32'h0},  // R5 only legacy set
        '{1'b0, 8'h04, 32'h0, 32'h0000_0002},  // R5
        '{1'b1, 8'h05, 32'hFFFF_FFFF, 32'h0},  // R5 upper config ignored
        '{1'b0, 8'h05, 32'h0, 32'h0},          // R5
        '{1'b1, 8'h3C, 32'h1234_5678, 32'h0},  // R4 load low half
        '{1'b1, 8'h3D, 32'h9ABC_DEF0, 32'h0},  // R4 load high half
        '{1'b0, 8'h3C, 32'h0, 32'h1234_5678},  // R4
        '{1'b0, 8'h3D, 32'h0, 32'h9ABC_DEF0},  // R4
        '{1'b0, 8'h08, 32'h0, 32'h0000_0005},  // R9 status view
        '{1'b0, 8'h30, 32'h0, 32'h0},          // R11 undecoded
        '{1'b0, 8'h4A, 32'h0, 32'hC0DE_0102},  // R7 slot 1 offset 2
        '{1'b0, 8'h45, 32'h0, 32'hC0DE_0005},  // R7 slot 0 offset 5
        '{1'b0, 8'h58, 32'h0, 32'h0}           // R8 slot 3 out of range
    };
    localparam string VTAG [NV] = '{"R2","R2","R2","R2","R5","R5","R5","R5",
                                    "R4","R4","R4","R4","R9","R11","R7","R7","R8"};

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 count", count_o, 64'd0);
        check("R10 enable", 64'(enabled_o), 64'd0);
        check("R10 pulses", 64'({arm_o, disarm_o, rsp_valid}), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) bus(1'b1, VEC[i].a, VEC[i].d);
            else           rd_chk(VTAG[i], VEC[i].a, VEC[i].exp);
        end

        // R1 write gives no response
        bus(1'b1, 8'h30, 32'h0);
        check("R1 no rsp on write", 64'(rsp_valid), 64'd0);

        // R7 write strobe, combinational in the request cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_waddr = 8'h4A; req_wdata = 32'hA5A5_0001;
        #1;
        check("R7 chan_wr", 64'(chan_wr), 64'b010);
        check("R7 chan_off", 64'(chan_off), 64'd2);
        check("R7 chan_wdata", 64'(chan_wdata), 64'hA5A5_0001);
        req_waddr = 8'hF8;  // R8 slot 23
        #1;
        check("R8 no strobe", 64'(chan_wr), 64'd0);
        req_waddr = 8'h08; req_wdata = 32'hFFFF_FFFF;  // R9 status clear
        #1;
        check("R9 sts_clr", 64'(sts_clr), 64'b101);
        req_wdata = 32'h0000_0004;
        #1;
        check("R9 sts_clr masked", 64'(sts_clr), 64'b100);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;

        // R3 / R6 counter run with carry
        bus(1'b1, 8'h3C, 32'hFFFF_FFFE);
        bus(1'b1, 8'h3D, 32'h0);
        bus(1'b1, 8'h04, 32'h1);
        check("R6 arm", 64'(arm_o), 64'b101);
        check("R6 no disarm", 64'(disarm_o), 64'd0);
        @(negedge clk);
        check("R6 arm one cycle", 64'(arm_o), 64'd0);
        tick = 1'b1;
        repeat (5) @(negedge clk);
        tick = 1'b0;
        check("R3 count", count_o, 64'h1_0000_0003);
        bus(1'b1, 8'h04, 32'h0);
        check("R6 disarm", 64'(disarm_o), 64'b111);
        check("R6 no arm", 64'(arm_o), 64'd0);
        tick = 1'b1;
        repeat (4) @(negedge clk);
        tick = 1'b0;
        check("R4 frozen", count_o, 64'h1_0000_0003);
        rd_chk("R4 lo", 8'h3C, 32'h3);
        rd_chk("R4 hi", 8'h3D, 32'h1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule